// File: doc/BRIEF.md
# Serial NOR Flash Slave Model

This block is a synthesizable slave that answers an SPI master in mode 0 the way a small serial NOR flash would. It samples the SCLK, chip-select and MOSI pins with the system clock, frames bytes from the moment chip-select falls, and drives MISO from a byte-wide internal memory, an eight-bit status register and fixed identification bytes. It is meant to stand in for a real flash part in a system model, or to be driven by a host controller under test.

Each transaction is one opcode byte followed by operand and data bytes. The block counts bytes within the transaction and uses the count to tell address, dummy, selector and data positions apart. Program and erase start when chip-select rises, then hold the busy flag for a fixed number of system cycles. While the busy flag is set, only the status read is honoured. Block-protect and the other upper status bits are stored and read back but are not enforced.

Top module: `spinor_flash`

## Requirements
- R1: After reset the status byte reads 0x00 and MISO is low.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1) and 0x04 clears it. Opcode 0x05 returns the live status byte on every byte after the opcode for as long as chip-select stays low. Status layout: bit0 busy, bit1 write-enable latch, bits 5:2 block protect, bit6 continuous-program flag, bit7 status-write disable.
- R3: Opcode 0x01 followed by one or two data bytes copies bits 7:2 of the first data byte into the status register on the rising edge of chip-select, provided the latch was set, and then clears the latch. Status bits 1:0 are never written this way. With the latch clear, or with any other number of data bytes, the status is unchanged and the latch keeps its value.
- R4: Opcode 0x03, then a 24-bit address sent most significant byte first, streams memory bytes from the fifth byte onward at successive addresses until chip-select rises. The memory index is the low MEM_AW address bits, so reads wrap at the end of memory.
- R5: Opcode 0x0B takes the same address plus one dummy byte, and data starts at the sixth byte.
- R6: Opcode 0x02 with a 24-bit address: with the latch set, each following byte is ANDed into memory at successive addresses. When chip-select rises after at least one such byte, the busy bit is set for PROG_CYC cycles, after which busy and the latch both clear. With the latch clear, memory is untouched.
- R7: Opcode 0x20 with a 24-bit address aligned to 2^SECT_AW bytes, with the latch set, sets every byte of that sector to 0xFF once chip-select rises. Busy is held during the erase and the latch clears at the end. A misaligned address or a clear latch leaves memory as it was, and the latch keeps its value.
- R8: Opcode 0x9F returns the manufacturer ID, then 0x20, then the device ID, in bytes two to four.
- R9: Opcode 0xAB followed by three dummy bytes returns the device ID in the fifth byte.
- R10: Opcode 0x90 followed by two dummy bytes and a selector byte returns two ID bytes. If selector bit 0 is 0, the manufacturer ID comes first and the device ID second. If it is 1, the order is reversed.
- R11: While busy is set, any opcode other than 0x05 is ignored: it returns zeros and changes no state.
- R12: MOSI is sampled on the rising edge of SCLK and MISO changes after the falling edge, most significant bit first. A byte is counted only when all eight of its rising edges occur while chip-select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, low when not selected |

## Verification
The assertions assume that each SCLK level lasts several system clocks, and that chip-select is stable for a few system clocks around every SCLK edge. Under these conditions the synchronised edge pulses are single, well separated events, and a byte-complete pulse always follows a sampled rising edge. The bench keeps every SCLK half period at six system clocks, and it changes MOSI and chip-select only while SCLK is low and well clear of an edge. It also waits long enough after chip-select rises for the release event to be taken before the next transaction starts.

// File: rtl/spinor_pkg.sv
package spinor_pkg;

  localparam logic [7:0] OP_NONE  = 8'h00;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_PP    = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_SE    = 8'h20;
  localparam logic [7:0] OP_REMS  = 8'h90;
  localparam logic [7:0] OP_RDID  = 8'h9F;
  localparam logic [7:0] OP_RES   = 8'hAB;

  localparam logic [7:0] MEM_TYPE = 8'h20;

  typedef struct packed {
    logic       srwd;
    logic       cp;
    logic [3:0] bp;
    logic       wel;
    logic       wip;
  } status_t;

  // byte position inside a transaction, held at 7 once reached
  function automatic logic [2:0] idx_step(logic [2:0] i);
    return (i == 3'd7) ? i : i + 3'd1;
  endfunction

  function automatic logic [23:0] addr_shift(logic [23:0] a, logic [7:0] b);
    return {a[15:0], b};
  endfunction

  function automatic logic is_aligned(logic [23:0] a, int unsigned sect_aw);
    return (a & ((24'd1 << sect_aw) - 24'd1)) == 24'd0;
  endfunction

  function automatic logic has_addr(logic [7:0] op);
    return op == OP_READ || op == OP_FREAD || op == OP_PP ||
           op == OP_SE   || op == OP_REMS;
  endfunction

endpackage

// File: rtl/spinor_pinsync.sv
module spinor_pinsync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_pin,
  input  logic cs_n_pin,
  input  logic mosi_pin,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic cs_rise,
  output logic mosi_s
);
  logic [2:0] sclk_q;
  logic [2:0] cs_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk_pin};
      cs_q   <= {cs_q[1:0], cs_n_pin};
      mosi_q <= {mosi_q[0], mosi_pin};
    end
  end

  assign sclk_rise = sclk_q[1] & ~sclk_q[2];
  assign sclk_fall = ~sclk_q[1] & sclk_q[2];
  assign cs_act    = ~cs_q[1];
  assign cs_rise   = cs_q[1] & ~cs_q[2];
  assign mosi_s    = mosi_q[1];
endmodule

// File: rtl/spinor_byte_io.sv
module spinor_byte_io (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_rise,
  input  logic       sclk_fall,
  input  logic       cs_act,
  input  logic       mosi_s,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       miso
);
  logic [2:0] bitcnt;
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt   <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!cs_act) begin
        bitcnt <= '0;
        tx_sh  <= '0;
      end else begin
        if (sclk_rise) begin
          rx_sh  <= {rx_sh[6:0], mosi_s};
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            rx_byte  <= {rx_sh[6:0], mosi_s};
            rx_valid <= 1'b1;
          end
        end
        if (sclk_fall)
          tx_sh <= (bitcnt == 3'd0) ? tx_byte : {tx_sh[6:0], 1'b0};
      end
    end
  end

  assign miso = tx_sh[7] & cs_act;

  // R12
  rx_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(sclk_rise && cs_act));
endmodule

// File: rtl/spinor_mem.sv
module spinor_mem #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/spinor_flash.sv
module spinor_flash
  import spinor_pkg::*;
#(
  parameter int          MEM_AW   = 12,
  parameter int          SECT_AW  = 12,
  parameter int          PROG_CYC = 256,
  parameter logic [7:0]  MFR_ID   = 8'hA5,
  parameter logic [7:0]  DEV_ID   = 8'h17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  localparam int PC_W  = $clog2(PROG_CYC + 1);
  localparam int CNT_W = ((SECT_AW > PC_W) ? SECT_AW : PC_W) + 1;
  localparam logic [MEM_AW-1:0] SECT_MASK  = MEM_AW'((64'd1 << SECT_AW) - 64'd1);
  localparam logic [CNT_W-1:0]  ERASE_LAST = CNT_W'((64'd1 << SECT_AW) - 64'd1);
  localparam logic [CNT_W-1:0]  PROG_LAST  = CNT_W'(PROG_CYC - 1);

  logic sclk_rise, sclk_fall, cs_act, cs_rise, mosi_s;
  logic [7:0] rx_byte, tx_next, mem_rd, mem_wd;
  logic rx_valid, mem_we;
  logic [MEM_AW-1:0] mem_wa, erase_idx;

  logic [7:0]       opcode;
  logic [2:0]       idx;
  logic [23:0]      addr;
  logic [7:0]       wsr_byte;
  logic             pp_hit;
  status_t          st;
  logic             erasing, programming;
  logic [CNT_W-1:0] cnt;

  // named internal events
  logic cmd_byte, addr_byte, pp_wr, rd_adv;
  logic start_prog, start_erase, wsr_apply, busy_done;

  spinor_pinsync u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_pin(sclk), .cs_n_pin(cs_n), .mosi_pin(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act),
    .cs_rise(cs_rise), .mosi_s(mosi_s)
  );

  spinor_byte_io u_bio (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .mosi_s(mosi_s), .tx_byte(tx_next),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .miso(miso)
  );

  spinor_mem #(.AW(MEM_AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
    .raddr(addr[MEM_AW-1:0]), .rdata(mem_rd)
  );

  assign cmd_byte    = rx_valid && idx == 3'd0;
  assign addr_byte   = rx_valid && idx >= 3'd1 && idx <= 3'd3 && has_addr(opcode);
  assign pp_wr       = rx_valid && opcode == OP_PP && idx >= 3'd4 && st.wel;
  assign rd_adv      = rx_valid && ((opcode == OP_READ  && idx >= 3'd4) ||
                                    (opcode == OP_FREAD && idx >= 3'd5));
  assign start_prog  = cs_rise && opcode == OP_PP && st.wel && pp_hit;
  assign start_erase = cs_rise && opcode == OP_SE && st.wel && idx >= 3'd4 &&
                       is_aligned(addr, SECT_AW);
  assign wsr_apply   = cs_rise && opcode == OP_WRSR && st.wel &&
                       (idx == 3'd2 || idx == 3'd3);
  assign busy_done   = (programming && cnt == '0) || (erasing && cnt == ERASE_LAST);

  assign erase_idx = (addr[MEM_AW-1:0] & ~SECT_MASK) | (MEM_AW'(cnt) & SECT_MASK);
  assign mem_we    = pp_wr || erasing;
  assign mem_wa    = erasing ? erase_idx : addr[MEM_AW-1:0];
  assign mem_wd    = erasing ? 8'hFF : (mem_rd & rx_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode      <= OP_NONE;
      idx         <= '0;
      addr        <= '0;
      wsr_byte    <= '0;
      pp_hit      <= 1'b0;
      st          <= '0;
      erasing     <= 1'b0;
      programming <= 1'b0;
      cnt         <= '0;
    end else begin
      if (rx_valid) idx <= idx_step(idx);
      if (cmd_byte) begin
        opcode <= (st.wip && rx_byte != OP_RDSR) ? OP_NONE : rx_byte;
        if (!st.wip && rx_byte == OP_WREN) st.wel <= 1'b1;
        if (!st.wip && rx_byte == OP_WRDI) st.wel <= 1'b0;
      end
      if (addr_byte) addr <= addr_shift(addr, rx_byte);
      if (rd_adv || pp_wr) addr <= addr + 24'd1;
      if (pp_wr) pp_hit <= 1'b1;
      if (rx_valid && opcode == OP_WRSR && idx == 3'd1) wsr_byte <= rx_byte;

      if (wsr_apply) begin
        st.srwd <= wsr_byte[7];
        st.cp   <= wsr_byte[6];
        st.bp   <= wsr_byte[5:2];
        st.wel  <= 1'b0;
      end

      if (cs_rise) begin
        opcode <= OP_NONE;
        idx    <= '0;
        pp_hit <= 1'b0;
      end

      if (start_prog) begin
        st.wip      <= 1'b1;
        programming <= 1'b1;
        cnt         <= PROG_LAST;
      end else if (start_erase) begin
        st.wip  <= 1'b1;
        erasing <= 1'b1;
        cnt     <= '0;
      end else if (busy_done) begin
        st.wip      <= 1'b0;
        st.wel      <= 1'b0;
        programming <= 1'b0;
        erasing     <= 1'b0;
      end else if (programming) begin
        cnt <= cnt - 1'b1;
      end else if (erasing) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    tx_next = 8'h00;
    case (opcode)
      OP_RDSR:  tx_next = st;
      OP_RDID: begin
        case (idx)
          3'd1:    tx_next = MFR_ID;
          3'd2:    tx_next = MEM_TYPE;
          3'd3:    tx_next = DEV_ID;
          default: tx_next = 8'h00;
        endcase
      end
      OP_RES:   if (idx >= 3'd4) tx_next = DEV_ID;
      OP_REMS: begin
        if (idx == 3'd4)      tx_next = addr[0] ? DEV_ID : MFR_ID;
        else if (idx == 3'd5) tx_next = addr[0] ? MFR_ID : DEV_ID;
      end
      OP_READ:  if (idx >= 3'd4) tx_next = mem_rd;
      OP_FREAD: if (idx >= 3'd5) tx_next = mem_rd;
      default:  tx_next = 8'h00;
    endcase
  end

  // R3
  sr_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st[7:2] != $past(st[7:2])) |-> $past(wsr_apply));

  // R6
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st.wip) |-> !st.wel);

  // R7
  erase_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erasing && $past(erasing)) |-> $stable(addr));

  // R11
  busy_cmd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_byte && st.wip && rx_byte != OP_RDSR) |=> (opcode == OP_NONE));

  // R11
  single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pp_wr && erasing));
endmodule

// File: tb/spinor_flash_tb.sv
module spinor_flash_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] d;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spinor_flash #(.MEM_AW(8), .SECT_AW(4), .PROG_CYC(700),
                 .MFR_ID(8'hA5), .DEV_ID(8'h17)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  function automatic logic [7:0] pat1(int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] pat2(int a);
    return 8'(((a * 91) ^ 8'h5A) & 255);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk);
      mosi = tx[b];
      repeat (HALF - 1) @(negedge clk);
      rx[b] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] x;
    cs_lo(); xfer(op, x); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] x;
    cs_lo(); xfer(8'h05, x); xfer(8'h00, s); cs_hi();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 60; k++) begin
      rdsr(s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] x;
    xfer(a[23:16], x); xfer(a[15:8], x); xfer(a[7:0], x);
  endtask

  task automatic read_chk(input logic fast, input logic [23:0] a, input int n, input string req);
    logic [7:0] x;
    cs_lo();
    xfer(fast ? 8'h0B : 8'h03, x);
    send_addr(a);
    if (fast) xfer(8'h00, x);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, x);
      chk(req, x, ref_mem[(int'(a[7:0]) + i) & 255]);
    end
    cs_hi();
  endtask

  task automatic erase(input logic [23:0] a);
    logic [7:0] x;
    op1(8'h06);
    cs_lo(); xfer(8'h20, x); send_addr(a); cs_hi();
    wait_idle();
    if (a[3:0] == 4'd0)
      for (int i = 0; i < 16; i++) ref_mem[(int'(a[7:0]) + i) & 255] = 8'hFF;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 miso", {7'd0, miso}, 8'h00);
    rdsr(d); chk("R1 status", d, 8'h00);

    // R2 latch set/clear, repeated status
    op1(8'h06);
    cs_lo(); xfer(8'h05, d);
    for (int k = 0; k < 3; k++) begin xfer(8'h00, d); chk("R2 repeat", d, 8'h02); end
    cs_hi();
    op1(8'h04); rdsr(d); chk("R2 clear", d, 8'h00);

    // R3 status write
    op1(8'h06);
    cs_lo(); xfer(8'h01, d); xfer(8'hFF, d); cs_hi();
    rdsr(d); chk("R3 applied", d, 8'hFC);
    cs_lo(); xfer(8'h01, d); xfer(8'h00, d); cs_hi();
    rdsr(d); chk("R3 no latch", d, 8'hFC);
    op1(8'h06);
    cs_lo(); xfer(8'h01, d); xfer(8'h00, d); xfer(8'h00, d); xfer(8'h00, d); cs_hi();
    rdsr(d); chk("R3 bad length", d, 8'hFE);
    cs_lo(); xfer(8'h01, d); xfer(8'h00, d); xfer(8'h00, d); cs_hi();
    rdsr(d); chk("R3 two bytes", d, 8'h00);

    // R7 erase every sector
    for (int s = 0; s < 16; s++) erase(24'(s * 16));
    op1(8'h06);
    cs_lo(); xfer(8'h20, d); send_addr(24'h000013); cs_hi();
    rdsr(d); chk("R7 misaligned", d, 8'h02);
    op1(8'h04);
    read_chk(1'b0, 24'h000000, 256, "R7 blank");

    // R6 program full memory
    op1(8'h06);
    cs_lo(); xfer(8'h02, d); send_addr(24'h000000);
    for (int a = 0; a < 256; a++) begin xfer(pat1(a), d); ref_mem[a] = ref_mem[a] & pat1(a); end
    cs_hi();
    cs_lo(); xfer(8'h05, d);
    xfer(8'h00, d); chk("R6 busy", d, 8'h03);
    xfer(8'h00, d); chk("R6 busy", d, 8'h03);
    cs_hi();
    // R11 identification ignored while busy
    cs_lo(); xfer(8'h9F, d); xfer(8'h00, d); chk("R11 ignored", d, 8'h00); cs_hi();
    wait_idle();
    rdsr(d); chk("R6 done", d, 8'h00);

    // R4 read, wrap; R5 fast read
    read_chk(1'b0, 24'h000000, 256, "R4");
    read_chk(1'b0, 24'h1234F0, 32, "R4 wrap");
    read_chk(1'b1, 24'h000040, 16, "R5");

    // R6 program without latch
    cs_lo(); xfer(8'h02, d); send_addr(24'h000020);
    for (int i = 0; i < 8; i++) xfer(8'h00, d);
    cs_hi();
    rdsr(d); chk("R6 no latch", d, 8'h00);
    read_chk(1'b0, 24'h000020, 8, "R6 no latch");

    // R6 AND into programmed data
    op1(8'h06);
    cs_lo(); xfer(8'h02, d); send_addr(24'h000080);
    for (int i = 0; i < 32; i++) begin
      xfer(pat2(i), d); ref_mem[128 + i] = ref_mem[128 + i] & pat2(i);
    end
    cs_hi();
    wait_idle();
    read_chk(1'b0, 24'h000078, 48, "R6 and");

    // R7 erase without latch, then real erase
    cs_lo(); xfer(8'h20, d); send_addr(24'h000080); cs_hi();
    read_chk(1'b0, 24'h000080, 16, "R7 no latch");
    erase(24'h000080);
    read_chk(1'b0, 24'h000070, 48, "R7 sector");

    // R8 identification
    cs_lo(); xfer(8'h9F, d);
    xfer(8'h00, d); chk("R8 mfr", d, 8'hA5);
    xfer(8'h00, d); chk("R8 type", d, 8'h20);
    xfer(8'h00, d); chk("R8 dev", d, 8'h17);
    cs_hi();

    // R9 release with ID
    cs_lo(); xfer(8'hAB, d); send_addr(24'h000000);
    xfer(8'h00, d); chk("R9 dev", d, 8'h17);
    cs_hi();

    // R10 selectable order
    cs_lo(); xfer(8'h90, d); send_addr(24'h000000);
    xfer(8'h00, d); chk("R10 sel0 first", d, 8'hA5);
    xfer(8'h00, d); chk("R10 sel0 second", d, 8'h17);
    cs_hi();
    cs_lo(); xfer(8'h90, d); send_addr(24'h000001);
    xfer(8'h00, d); chk("R10 sel1 first", d, 8'h17);
    xfer(8'h00, d); chk("R10 sel1 second", d, 8'hA5);
    cs_hi();

    // R12 MISO idle low after release
    chk("R12 idle", {7'd0, miso}, 8'h00);

    summary();
    $finish;
  end
endmodule